// File: doc/BRIEF.md
# Processor Bus Cycle Sequencer

This block sits between a 16-bit processor core and its external bus. It runs every machine cycle the core asks for: internal, instruction fetch, operand read, operand write, IO read and IO write. For each one it drives a three-line status code, an address strobe, read and write strobes and a data strobe. Internal cycles use no bus. Bus cycles can be stretched by a slow device through a ready input. Read data returns to the core with a one-clock done pulse.

Three kinds of event can change the flow of cycles: console requests, interrupt requests and taken branches. The sequencer looks at them only at a cycle boundary. A boundary is a clock in which no cycle is running, or the final clock of a cycle. An accepted interrupt or branch makes the block issue two back-to-back instruction fetches, at the target address and at the next address. The fetched words go out on a separate fill port. The core holds each request line high until the matching take output is seen.

Top module: `bus_cycle_sequencer`

## Requirements
- R1: The cycle type code (0 internal, 1 fetch, 2 operand read, 3 operand write, 4 IO read, 5 IO write; 6 and 7 run as internal) sets the status lines during the cycle. bus_rw_n is low only for codes 3 and 5. bus_oi_n is high only for codes 2 to 5. bus_mio_n is low only for codes 4 and 5. bus_addr carries the full 16-bit address for memory and IO cycles. When the block is idle the lines read rw_n=1, oi_n=0, mio_n=1.
- R2: An internal cycle lasts exactly two clocks, leaves all four strobes high, and ignores bus_ready.
- R3: In a bus cycle, bus_as_n is low in the first clock only. From the second clock to the end of the cycle, bus_ds_n is low together with bus_rd_n (codes 1, 2, 4) or bus_wr_n (codes 3, 5).
- R4: bus_ready is sampled from the second clock of a bus cycle onward. Each clock with bus_ready low adds one clock with the strobes held, and the cycle ends in the first clock with bus_ready high.
- R5: For a core request, done is high for exactly one clock, the clock after the final clock of the cycle. For read codes, rdata then holds the bus_din value sampled in the final clock. During write codes, bus_oe is high and bus_dout carries the request's write data.
- R6: The console, interrupt, branch and core request inputs are accepted (their take output goes high) only at a cycle boundary, never in the first or a wait clock of a cycle.
- R7: At a boundary, the second fetch of a refill comes first, then console, then interrupt, then branch, then a core request. At most one take output is high at a time.
- R8: An accepted interrupt or branch starts, in the next clock, two consecutive fetch cycles at the target address and at target+1 (wrapping at 16 bits). Each fetched word appears on fill_data with a one-clock fill_valid, and done stays low for these fetches.
- R9: During and right after reset the block is idle: all strobes high, rw_n=1, oi_n=0, mio_n=1, done and fill_valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core requests a machine cycle, held until req_take |
| req_type | input | 3 | Cycle type code |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 16 | Write data for write codes |
| req_take | output | 1 | Core request accepted at this edge |
| done | output | 1 | One-clock pulse when a core cycle has completed |
| rdata | output | 16 | Data from the last completed read cycle |
| br_req | input | 1 | Taken branch pending, held until br_take |
| br_addr | input | 16 | Branch target |
| br_take | output | 1 | Branch accepted at this edge |
| irq_req | input | 1 | Interrupt pending, held until irq_take |
| irq_vec | input | 16 | Interrupt target address |
| irq_take | output | 1 | Interrupt accepted at this edge |
| con_req | input | 1 | Console request pending, held until con_take |
| con_take | output | 1 | Console request accepted at this edge |
| fill_valid | output | 1 | One-clock pulse with a refill word |
| fill_data | output | 16 | Refill fetch word |
| bus_addr | output | 16 | External address |
| bus_dout | output | 16 | External write data |
| bus_oe | output | 1 | Write data drive enable |
| bus_din | input | 16 | External read data |
| bus_ready | input | 1 | Device ready, low inserts a wait state |
| bus_rw_n | output | 1 | Status: low for writes |
| bus_oi_n | output | 1 | Status: low for internal and fetch |
| bus_mio_n | output | 1 | Status: low for IO space |
| bus_as_n | output | 1 | Address strobe |
| bus_rd_n | output | 1 | Read strobe |
| bus_wr_n | output | 1 | Write strobe |
| bus_ds_n | output | 1 | Data strobe |

## Verification
The bench raises an interrupt in the middle of a cycle that is stretched by wait states. A sequencer that accepts events mid-cycle would pulse irq_take early and cut the read short. It keeps a core request pending across a refill, which catches a design that slips the request in between the two refill fetches. It raises console, interrupt and branch at once to expose a wrong priority, and it branches to the top address to catch a second fetch that does not wrap. Internal cycles are run with ready held low. A design that wrongly waits on ready would hang, or would pulse done late.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    typedef enum logic [2:0] {
        CYC_INT   = 3'd0,
        CYC_FETCH = 3'd1,
        CYC_ORD   = 3'd2,
        CYC_OWR   = 3'd3,
        CYC_IORD  = 3'd4,
        CYC_IOWR  = 3'd5
    } cyc_e;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_REFILL,
        SEL_CON,
        SEL_IRQ,
        SEL_BR,
        SEL_REQ
    } sel_e;

    function automatic cyc_e to_cyc(input logic [2:0] code);
        case (code)
            3'd1:    return CYC_FETCH;
            3'd2:    return CYC_ORD;
            3'd3:    return CYC_OWR;
            3'd4:    return CYC_IORD;
            3'd5:    return CYC_IOWR;
            default: return CYC_INT;
        endcase
    endfunction

    function automatic logic cyc_is_write(input cyc_e t);
        return (t == CYC_OWR) || (t == CYC_IOWR);
    endfunction

    function automatic logic cyc_is_io(input cyc_e t);
        return (t == CYC_IORD) || (t == CYC_IOWR);
    endfunction

    function automatic logic cyc_is_read(input cyc_e t);
        return (t == CYC_FETCH) || (t == CYC_ORD) || (t == CYC_IORD);
    endfunction

endpackage

// File: rtl/bcs_arbiter.sv
module bcs_arbiter
    import bcs_pkg::*;
(
    input  logic boundary,
    input  logic refill_pend,
    input  logic con_req,
    input  logic irq_req,
    input  logic br_req,
    input  logic req_valid,
    output sel_e sel
);

    always_comb begin
        sel = SEL_NONE;
        if (boundary) begin
            if (refill_pend)    sel = SEL_REFILL;
            else if (con_req)   sel = SEL_CON;
            else if (irq_req)   sel = SEL_IRQ;
            else if (br_req)    sel = SEL_BR;
            else if (req_valid) sel = SEL_REQ;
        end
    end

endmodule

// File: rtl/bcs_lines.sv
module bcs_lines
    import bcs_pkg::*;
(
    input  logic active,
    input  cyc_e typ,
    input  logic late,
    output logic rw_n,
    output logic oi_n,
    output logic mio_n,
    output logic as_n,
    output logic rd_n,
    output logic wr_n,
    output logic ds_n,
    output logic oe
);

    logic on_bus;
    logic wr;

    always_comb begin
        on_bus = active && (typ != CYC_INT);
        wr     = cyc_is_write(typ);
        rw_n   = !(active && wr);
        oi_n   = active && (typ != CYC_INT) && (typ != CYC_FETCH);
        mio_n  = !(active && cyc_is_io(typ));
        as_n   = !(on_bus && !late);
        ds_n   = !(on_bus && late);
        rd_n   = !(on_bus && late && !wr);
        wr_n   = !(on_bus && late && wr);
        oe     = active && wr;
    end

endmodule

// File: rtl/bus_cycle_sequencer.sv
module bus_cycle_sequencer
    import bcs_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 16,
    parameter int REFILL_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_type,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_take,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    input  logic              br_req,
    input  logic [ADDR_W-1:0] br_addr,
    output logic              br_take,
    input  logic              irq_req,
    input  logic [ADDR_W-1:0] irq_vec,
    output logic              irq_take,
    input  logic              con_req,
    output logic              con_take,
    output logic              fill_valid,
    output logic [DATA_W-1:0] fill_data,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_oe,
    input  logic [DATA_W-1:0] bus_din,
    input  logic              bus_ready,
    output logic              bus_rw_n,
    output logic              bus_oi_n,
    output logic              bus_mio_n,
    output logic              bus_as_n,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    output logic              bus_ds_n
);

    localparam int CNT_W = $clog2(REFILL_N + 1);

    typedef struct packed {
        logic              active;
        cyc_e              typ;
        logic              late;
        logic              fill;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [CNT_W-1:0]  left;
        logic              done;
        logic [DATA_W-1:0] rdata;
        logic              fill_valid;
        logic [DATA_W-1:0] fill_data;
    } seq_t;

    seq_t st_q, st_d;
    logic cyc_end;
    logic boundary;
    sel_e sel;

    bcs_arbiter u_arb (
        .boundary   (boundary),
        .refill_pend(st_q.left != '0),
        .con_req    (con_req),
        .irq_req    (irq_req),
        .br_req     (br_req),
        .req_valid  (req_valid),
        .sel        (sel)
    );

    always_comb begin
        cyc_end  = st_q.active && st_q.late && ((st_q.typ == CYC_INT) || bus_ready);
        boundary = !st_q.active || cyc_end;

        st_d            = st_q;
        st_d.done       = 1'b0;
        st_d.fill_valid = 1'b0;

        if (st_q.active && !st_q.late) begin
            st_d.late = 1'b1;
        end

        if (cyc_end) begin
            st_d.active = 1'b0;
            st_d.late   = 1'b0;
            if (st_q.fill) begin
                st_d.fill_valid = 1'b1;
                st_d.fill_data  = bus_din;
            end else begin
                st_d.done = 1'b1;
                if (cyc_is_read(st_q.typ)) begin
                    st_d.rdata = bus_din;
                end
            end
        end

        case (sel)
            SEL_REFILL: begin
                st_d.active = 1'b1;
                st_d.late   = 1'b0;
                st_d.typ    = CYC_FETCH;
                st_d.fill   = 1'b1;
                st_d.addr   = st_q.addr + ADDR_W'(1);
                st_d.left   = st_q.left - CNT_W'(1);
            end
            SEL_IRQ: begin
                st_d.active = 1'b1;
                st_d.late   = 1'b0;
                st_d.typ    = CYC_FETCH;
                st_d.fill   = 1'b1;
                st_d.addr   = irq_vec;
                st_d.left   = CNT_W'(REFILL_N - 1);
            end
            SEL_BR: begin
                st_d.active = 1'b1;
                st_d.late   = 1'b0;
                st_d.typ    = CYC_FETCH;
                st_d.fill   = 1'b1;
                st_d.addr   = br_addr;
                st_d.left   = CNT_W'(REFILL_N - 1);
            end
            SEL_REQ: begin
                st_d.active = 1'b1;
                st_d.late   = 1'b0;
                st_d.typ    = to_cyc(req_type);
                st_d.fill   = 1'b0;
                st_d.addr   = req_addr;
                st_d.wdata  = req_wdata;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{
                active:     1'b0,
                typ:        CYC_INT,
                late:       1'b0,
                fill:       1'b0,
                addr:       '0,
                wdata:      '0,
                left:       '0,
                done:       1'b0,
                rdata:      '0,
                fill_valid: 1'b0,
                fill_data:  '0
            };
        end else begin
            st_q <= st_d;
        end
    end

    bcs_lines u_lines (
        .active(st_q.active),
        .typ   (st_q.typ),
        .late  (st_q.late),
        .rw_n  (bus_rw_n),
        .oi_n  (bus_oi_n),
        .mio_n (bus_mio_n),
        .as_n  (bus_as_n),
        .rd_n  (bus_rd_n),
        .wr_n  (bus_wr_n),
        .ds_n  (bus_ds_n),
        .oe    (bus_oe)
    );

    assign req_take   = (sel == SEL_REQ);
    assign br_take    = (sel == SEL_BR);
    assign irq_take   = (sel == SEL_IRQ);
    assign con_take   = (sel == SEL_CON);
    assign done       = st_q.done;
    assign rdata      = st_q.rdata;
    assign fill_valid = st_q.fill_valid;
    assign fill_data  = st_q.fill_data;
    assign bus_addr   = st_q.addr;
    assign bus_dout   = st_q.wdata;

endmodule

// File: rtl/bcs_checker.sv
module bcs_checker (
    input logic clk,
    input logic rst_n,
    input logic as_n,
    input logic ds_n,
    input logic rd_n,
    input logic wr_n,
    input logic rw_n,
    input logic oi_n,
    input logic mio_n,
    input logic ready,
    input logic done,
    input logic fill_valid,
    input logic [3:0] takes
);

    assert_as_one_clock_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !as_n |=> as_n);

    assert_ds_after_as_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !as_n |=> !ds_n);

    assert_read_status_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> (rw_n && !ds_n));

    assert_write_status_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> (!rw_n && !ds_n));

    assert_wait_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ds_n && !ready) |=> (!ds_n && as_n));

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_no_take_first_clock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !as_n |-> (takes == 4'b0000));

    assert_single_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(takes));

    assert_irq_starts_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        takes[2] |=> (!as_n && !oi_n && rw_n && mio_n));

    assert_fill_not_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> !done);

endmodule

bind bus_cycle_sequencer bcs_checker u_bcs_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .as_n      (bus_as_n),
    .ds_n      (bus_ds_n),
    .rd_n      (bus_rd_n),
    .wr_n      (bus_wr_n),
    .rw_n      (bus_rw_n),
    .oi_n      (bus_oi_n),
    .mio_n     (bus_mio_n),
    .ready     (bus_ready),
    .done      (done),
    .fill_valid(fill_valid),
    .takes     ({con_take, irq_take, br_take, req_take})
);

// File: tb/bus_cycle_sequencer_test.sv
module bus_cycle_sequencer_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] KEY = 16'h5A3C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic        req_valid = 1'b0;
    logic [2:0]  req_type = '0;
    logic [15:0] req_addr = '0, req_wdata = '0;
    logic        req_take, done, br_take, irq_take, con_take, fill_valid;
    logic [15:0] rdata, fill_data, bus_addr, bus_dout, bus_din;
    logic        br_req = 1'b0, irq_req = 1'b0, con_req = 1'b0;
    logic [15:0] br_addr = '0, irq_vec = '0;
    logic        bus_oe, bus_ready = 1'b0;
    logic        bus_rw_n, bus_oi_n, bus_mio_n, bus_as_n, bus_rd_n, bus_wr_n, bus_ds_n;

    assign bus_din = bus_addr ^ KEY;
    wire [3:0] takes = {con_take, irq_take, br_take, req_take};

    bus_cycle_sequencer uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_type(req_type), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_take(req_take), .done(done), .rdata(rdata),
        .br_req(br_req), .br_addr(br_addr), .br_take(br_take),
        .irq_req(irq_req), .irq_vec(irq_vec), .irq_take(irq_take),
        .con_req(con_req), .con_take(con_take),
        .fill_valid(fill_valid), .fill_data(fill_data),
        .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_oe(bus_oe), .bus_din(bus_din),
        .bus_ready(bus_ready),
        .bus_rw_n(bus_rw_n), .bus_oi_n(bus_oi_n), .bus_mio_n(bus_mio_n),
        .bus_as_n(bus_as_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_ds_n(bus_ds_n)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit ended = 1'b0;

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    function automatic bit e_rw(input logic [2:0] t); return !(t == 3'd3 || t == 3'd5); endfunction
    function automatic bit e_oi(input logic [2:0] t); return (t >= 3'd2 && t <= 3'd5); endfunction
    function automatic bit e_mio(input logic [2:0] t); return !(t == 3'd4 || t == 3'd5); endfunction
    function automatic bit is_bus(input logic [2:0] t); return (t >= 3'd1 && t <= 3'd5); endfunction
    function automatic bit is_wr(input logic [2:0] t); return (t == 3'd3 || t == 3'd5); endfunction
    function automatic bit is_rd(input logic [2:0] t); return (t == 3'd1 || t == 3'd2 || t == 3'd4); endfunction

    task automatic check_lines(input logic [2:0] t);
        chk(bus_rw_n == e_rw(t), "R1", "rw_n", bus_rw_n, e_rw(t));
        chk(bus_oi_n == e_oi(t), "R1", "oi_n", bus_oi_n, e_oi(t));
        chk(bus_mio_n == e_mio(t), "R1", "mio_n", bus_mio_n, e_mio(t));
    endtask

    // Entered in the first clock of a cycle (settled); leaves in its final clock with ready driven.
    task automatic cyc_body(input logic [2:0] t, input logic [15:0] a, input logic [15:0] wd, input int nw);
        check_lines(t);
        chk(takes == 4'b0, "R6", "take in first clock", takes, 0);
        if (is_bus(t)) begin
            chk(bus_as_n == 1'b0, "R3", "as_n first clock", bus_as_n, 0);
            chk({bus_ds_n, bus_rd_n, bus_wr_n} == 3'b111, "R3", "strobes first clock",
                {bus_ds_n, bus_rd_n, bus_wr_n}, 7);
            chk(bus_addr == a, "R1", "bus_addr", bus_addr, a);
            if (is_wr(t)) chk(bus_oe && bus_dout == wd, "R5", "write data", bus_dout, wd);
        end else begin
            chk({bus_as_n, bus_ds_n, bus_rd_n, bus_wr_n} == 4'hF, "R2", "internal strobes",
                {bus_as_n, bus_ds_n, bus_rd_n, bus_wr_n}, 15);
        end
        @(negedge clk);
        bus_ready = is_bus(t) ? (nw == 0) : 1'b0;
        #1;
        check_lines(t);
        if (is_bus(t)) begin
            chk(bus_as_n && !bus_ds_n, "R3", "as/ds second clock", {bus_as_n, bus_ds_n}, 2);
            chk(bus_rd_n == !is_rd(t) && bus_wr_n == !is_wr(t), "R3", "rd/wr strobes",
                {bus_rd_n, bus_wr_n}, {!is_rd(t), !is_wr(t)});
            if (nw > 0) chk(takes == 4'b0, "R6", "take in wait clock", takes, 0);
            for (int w = 1; w <= nw; w++) begin
                @(negedge clk);
                bus_ready = (w == nw);
                #1;
                chk(!bus_ds_n && bus_as_n, "R4", "strobe held in wait", {bus_as_n, bus_ds_n}, 2);
                check_lines(t);
                if (w < nw) chk(takes == 4'b0, "R6", "take in wait clock", takes, 0);
            end
        end else begin
            chk({bus_as_n, bus_ds_n, bus_rd_n, bus_wr_n} == 4'hF, "R2", "internal strobes",
                {bus_as_n, bus_ds_n, bus_rd_n, bus_wr_n}, 15);
        end
    endtask

    task automatic do_req(input logic [2:0] t, input logic [15:0] a, input logic [15:0] wd, input int nw);
        req_type = t; req_addr = a; req_wdata = wd; req_valid = 1'b1;
        #1;
        chk(req_take == 1'b1, "R6", "request taken when idle", req_take, 1);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        cyc_body(t, a, wd, nw);
        @(negedge clk);
        bus_ready = 1'b0;
        #1;
        chk(done == 1'b1, "R5", "done after final clock", done, 1);
        if (is_rd(t)) chk(rdata == (a ^ KEY), "R5", "read data", rdata, a ^ KEY);
        chk(bus_as_n && bus_ds_n, "R4", "cycle ended on time", {bus_as_n, bus_ds_n}, 3);
        @(negedge clk);
        #1;
        chk(done == 1'b0, "R5", "done lasts one clock", done, 0);
    endtask

    task automatic fill_check(input logic [15:0] a);
        chk(fill_valid == 1'b1, "R8", "fill_valid", fill_valid, 1);
        chk(fill_data == (a ^ KEY), "R8", "fill_data", fill_data, a ^ KEY);
        chk(done == 1'b0, "R8", "no done for refill", done, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed_dummy;
        seed_dummy = $urandom(32'd1750);
        repeat (3) @(negedge clk);
        #1;
        // R9 reset state
        chk({bus_as_n, bus_ds_n, bus_rd_n, bus_wr_n} == 4'hF, "R9", "strobes in reset",
            {bus_as_n, bus_ds_n, bus_rd_n, bus_wr_n}, 15);
        check_lines(3'd0);
        chk(!done && !fill_valid, "R9", "done/fill in reset", {done, fill_valid}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(bus_oi_n == 1'b0 && bus_as_n, "R9", "idle after reset", {bus_oi_n, bus_as_n}, 1);

        // Directed: each type, no waits; internal with ready held low (R2)
        for (int t = 0; t <= 5; t++) do_req(3'(t), 16'h1000 + 16'(t), 16'hC0DE + 16'(t), 0);
        // IO space at top address, with waits (R1, R4)
        do_req(3'd4, 16'hFFFF, 16'h0, 3);
        do_req(3'd5, 16'h8001, 16'hBEEF, 2);

        // Interrupt raised mid-cycle, core request pending across refill (R6, R7, R8)
        req_type = 3'd2; req_addr = 16'h0444; req_valid = 1'b1;
        #1;
        chk(req_take == 1'b1, "R6", "read taken", req_take, 1);
        @(negedge clk);
        req_valid = 1'b0;
        irq_req = 1'b1; irq_vec = 16'h0200;
        #1;
        cyc_body(3'd2, 16'h0444, 16'h0, 3);
        chk(irq_take == 1'b1, "R6", "irq taken at final clock", irq_take, 1);
        req_type = 3'd3; req_addr = 16'h0555; req_wdata = 16'h1234; req_valid = 1'b1;
        #1;
        chk(req_take == 1'b0, "R7", "irq beats request", req_take, 0);
        @(negedge clk);
        irq_req = 1'b0;
        #1;
        chk(done == 1'b1 && rdata == (16'h0444 ^ KEY), "R5", "read done before refill", rdata, 16'h0444 ^ KEY);
        cyc_body(3'd1, 16'h0200, 16'h0, 0);
        chk(req_take == 1'b0, "R7", "refill second fetch first", req_take, 0);
        @(negedge clk);
        #1;
        fill_check(16'h0200);
        cyc_body(3'd1, 16'h0201, 16'h0, 1);
        chk(req_take == 1'b1, "R7", "request after refill", req_take, 1);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        fill_check(16'h0201);
        cyc_body(3'd3, 16'h0555, 16'h1234, 0);
        @(negedge clk);
        bus_ready = 1'b0;
        #1;
        chk(done == 1'b1, "R5", "write done", done, 1);

        // Console, interrupt and branch together; branch at top address wraps (R7, R8)
        @(negedge clk);
        con_req = 1'b1; irq_req = 1'b1; br_req = 1'b1; irq_vec = 16'h0300; br_addr = 16'hFFFF;
        #1;
        chk(takes == 4'b1000, "R7", "console first", takes, 8);
        @(negedge clk);
        con_req = 1'b0;
        #1;
        chk(takes == 4'b0100, "R7", "interrupt second", takes, 4);
        @(negedge clk);
        irq_req = 1'b0;
        #1;
        cyc_body(3'd1, 16'h0300, 16'h0, 0);
        chk(br_take == 1'b0, "R7", "branch waits for refill", br_take, 0);
        @(negedge clk);
        #1;
        fill_check(16'h0300);
        cyc_body(3'd1, 16'h0301, 16'h0, 1);
        chk(br_take == 1'b1, "R7", "branch after refill", br_take, 1);
        @(negedge clk);
        br_req = 1'b0;
        #1;
        fill_check(16'h0301);
        cyc_body(3'd1, 16'hFFFF, 16'h0, 2);
        chk(takes == 4'b0, "R6", "nothing pending", takes, 0);
        @(negedge clk);
        #1;
        fill_check(16'hFFFF);
        cyc_body(3'd1, 16'h0000, 16'h0, 0);
        @(negedge clk);
        bus_ready = 1'b0;
        #1;
        fill_check(16'h0000);

        // Constrained random core cycles (R1 to R5 across patterns)
        for (int i = 0; i < 40; i++) begin
            do_req(3'($urandom_range(5, 0)), 16'($urandom), 16'($urandom), int'($urandom_range(4, 0)));
        end

        ended = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule